// File: doc/BRIEF.md
# XGMII Transmit Frame Encapsulator

This block sits between a client that streams whole Ethernet frames (FCS already appended) and a 32-bit XGMII transmit interface with one control bit per byte lane. It wraps every frame in a start column, a preamble and a start-of-frame delimiter. It closes the frame with a terminate control character and spaces frames with idle control characters. Every frame start lands in lane 0.

The client drives a beat of data with a per-byte valid mask, a valid flag and a last flag. The block accepts a beat only while its ready output is high. Ready stays low while the start and preamble columns go out and through the inter-packet gap. Because the gap must end on a column boundary, the block keeps a small deficit count. It shortens some gaps and lengthens others so that the average gap stays at the configured byte count.

Top module: `xgmii_tx_encap`

## Requirements
- R1: After reset, and whenever no frame is being sent, every lane carries the idle code 0x07 and all control bits are 1. Control bit n marks lane n (bits 8n+7:8n) as a control character. The ready output is 0 while idle.
- R2: A frame begins with a start column: lane 0 holds 0xFB with its control bit set, and lanes 1 to 3 hold 0x55. The next column is 0x55, 0x55, 0x55, 0xD5 in lanes 0 to 3, with no control bits set. 0xFB never appears as a control character outside lane 0.
- R3: Each accepted beat appears on the next output column. Client byte i (bits 8i+7:8i) goes to lane i with its control bit clear. Beats appear in order.
- R4: On the last beat with c valid bytes (the mask is contiguous from bit 0, with 1 ≤ c ≤ 4): if c < 4, lane c holds 0xFD as control and higher lanes hold 0x07 as control. If c = 4, the following column is 0xFD in lane 0 and 0x07 in lanes 1 to 3, all as control.
- R5: Let the gap be the terminate byte plus the idle bytes before the next start, and let r = c mod 4. The deficit count is 0 at reset. If deficit + r ≤ 3, the gap is IPG_BYTES − r and the deficit grows by r. Otherwise the gap is IPG_BYTES + 4 − r and the deficit shrinks by 4 − r.
- R6: With the default IPG_BYTES of 12, every gap is between 9 and 15 bytes.
- R7: Ready is 0 during the start column, during the gap and while idle. It first goes high while the 0xD5 column is on the output. It stays high until the last beat is accepted.
- R8: If valid is low during a cycle with ready high inside a frame, that cycle's column is 0xFE in every lane with all control bits set. The frame then continues.
- R9: When the next frame's first beat is already waiting as the gap ends, the start column follows the last gap column with no extra idle.
- R10: Lanes marked as control only ever carry 0x07, 0xFB, 0xFD or 0xFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_data | input | 32 | Client beat, byte i in bits 8i+7:8i |
| s_keep | input | 4 | Byte-valid mask for the beat |
| s_valid | input | 1 | Beat is present |
| s_last | input | 1 | Beat is the last of the frame |
| s_ready | output | 1 | Block accepts the beat this cycle |
| xgmii_txd | output | 32 | XGMII transmit data |
| xgmii_txc | output | 4 | XGMII transmit control, bit n for lane n |

## Verification
The assertions assume a well-formed client. The byte-valid mask of a last beat is contiguous from bit 0 and never empty. Every beat that is not last is full. A beat is held steady while valid is high and ready is low. The stimulus builds every frame from whole beats with only the last one partial, and holds each beat until it sees ready at a falling edge. Valid drops mid-frame only on purpose, to test the error column. Gap lengths are checked exactly on back-to-back bursts, where the next frame waits with valid high through the gap.

// File: rtl/xte_pkg.sv
package xte_pkg;
   localparam logic [7:0] XC_IDLE  = 8'h07;
   localparam logic [7:0] XC_START = 8'hFB;
   localparam logic [7:0] XC_TERM  = 8'hFD;
   localparam logic [7:0] XC_ERR   = 8'hFE;
   localparam logic [7:0] XB_PRE   = 8'h55;
   localparam logic [7:0] XB_SFD   = 8'hD5;
   // bytes from start character through SFD
   localparam int unsigned LEAD_BYTES = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_DATA,
      ST_TERM,
      ST_GAP
   } tx_state_t;
endpackage

// File: rtl/xte_dic.sv
// Deficit idle counter: running count of bytes that gaps have been shortened by,
// kept modulo the column width. A carry out means the shortfall is repaid.
module xte_dic #(
   parameter int unsigned LANES = 4,
   localparam int unsigned RW = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [RW-1:0] resid,
   output logic          stretch
);
   logic [RW-1:0] dic_q;
   logic [RW:0]   sum;

   assign sum     = {1'b0, dic_q} + {1'b0, resid};
   assign stretch = sum[RW];

   always_ff @(posedge clk) begin
      if (!rst_n)   dic_q <= '0;
      else if (upd) dic_q <= sum[RW-1:0];
   end
endmodule

// File: rtl/xte_col_build.sv
// Builds the output column for a client beat, placing the terminate character
// after the last valid byte when the beat closes the frame.
module xte_col_build
   import xte_pkg::*;
#(
   parameter int unsigned LANES = 4,
   localparam int unsigned DW = 8 * LANES
) (
   input  logic [DW-1:0]    data,
   input  logic [LANES-1:0] keep,
   input  logic             last,
   output logic [DW-1:0]    col_d,
   output logic [LANES-1:0] col_c
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic term_here;
      if (i == 0) begin : g_first
         assign term_here = last & ~keep[0];
      end else begin : g_rest
         assign term_here = last & ~keep[i] & keep[i-1];
      end
      assign col_c[i]       = last & ~keep[i];
      assign col_d[8*i +: 8] = (!last || keep[i]) ? data[8*i +: 8]
                             : (term_here ? XC_TERM : XC_IDLE);
   end
endmodule

// File: rtl/xgmii_tx_encap.sv
module xgmii_tx_encap
   import xte_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned IPG_BYTES = 12,
   localparam int unsigned DW       = 8 * LANES,
   localparam int unsigned RW       = $clog2(LANES),
   localparam int unsigned IPG_COLS = IPG_BYTES / LANES,
   localparam int unsigned GW       = $clog2(IPG_COLS + 1),
   localparam int unsigned PRE_COLS = LEAD_BYTES / LANES,
   localparam int unsigned PW       = $clog2(PRE_COLS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    s_data,
   input  logic [LANES-1:0] s_keep,
   input  logic             s_valid,
   input  logic             s_last,
   output logic             s_ready,
   output logic [DW-1:0]    xgmii_txd,
   output logic [LANES-1:0] xgmii_txc
);
   if (LANES != 4 && LANES != 8) begin : g_bad_lanes
      $error("xgmii_tx_encap: LANES must be 4 or 8");
   end
   if (IPG_BYTES % LANES != 0 || IPG_BYTES < 2 * LANES) begin : g_bad_ipg
      $error("xgmii_tx_encap: IPG_BYTES must be a multiple of LANES and at least two columns");
   end

   localparam logic [PW-1:0] PRE_LAST = PW'(PRE_COLS - 1);
   localparam logic [DW-1:0] IDLE_COL = {LANES{XC_IDLE}};
   localparam logic [DW-1:0] TERM_COL = {{(LANES-1){XC_IDLE}}, XC_TERM};
   localparam logic [DW-1:0] ERR_COL  = {LANES{XC_ERR}};

   tx_state_t        state;
   logic [PW-1:0]    pidx;
   logic [GW-1:0]    gleft;
   logic [DW-1:0]    pre_d;
   logic [LANES-1:0] pre_c;
   logic [DW-1:0]    beat_d;
   logic [LANES-1:0] beat_c;
   logic [RW:0]      kcnt;
   logic             stretch;
   logic             close_beat;

   assign s_ready    = (state == ST_DATA);
   assign close_beat = s_ready & s_valid & s_last;

   // preamble column: byte position within the lead-in selects start, 0x55 or SFD
   always_comb begin
      logic [PW-1:0] pcol;
      pcol = (state == ST_IDLE) ? '0 : pidx;
      for (int i = 0; i < LANES; i++) begin
         int unsigned p;
         p = int'(pcol) * LANES + i;
         pre_c[i] = (p == 0);
         if (p == 0)                   pre_d[8*i +: 8] = XC_START;
         else if (p == LEAD_BYTES - 1) pre_d[8*i +: 8] = XB_SFD;
         else                          pre_d[8*i +: 8] = XB_PRE;
      end
   end

   always_comb begin
      kcnt = '0;
      for (int i = 0; i < LANES; i++) kcnt = kcnt + {{RW{1'b0}}, s_keep[i]};
   end

   xte_col_build #(.LANES(LANES)) u_col (
      .data (s_data),
      .keep (s_keep),
      .last (s_last),
      .col_d(beat_d),
      .col_c(beat_c)
   );

   xte_dic #(.LANES(LANES)) u_dic (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (close_beat),
      .resid  (kcnt[RW-1:0]),
      .stretch(stretch)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pidx      <= '0;
         gleft     <= '0;
         xgmii_txd <= IDLE_COL;
         xgmii_txc <= '1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (s_valid) begin
                  xgmii_txd <= pre_d;
                  xgmii_txc <= pre_c;
                  pidx      <= PW'(1);
                  state     <= (PRE_COLS == 1) ? ST_DATA : ST_PRE;
               end else begin
                  xgmii_txd <= IDLE_COL;
                  xgmii_txc <= '1;
               end
            end
            ST_PRE: begin
               xgmii_txd <= pre_d;
               xgmii_txc <= pre_c;
               pidx      <= pidx + PW'(1);
               if (pidx == PRE_LAST) state <= ST_DATA;
            end
            ST_DATA: begin
               if (s_valid) begin
                  xgmii_txd <= beat_d;
                  xgmii_txc <= beat_c;
                  if (s_last) begin
                     if (&s_keep) begin
                        state <= ST_TERM;
                     end else begin
                        state <= ST_GAP;
                        gleft <= stretch ? GW'(IPG_COLS) : GW'(IPG_COLS - 1);
                     end
                  end
               end else begin
                  xgmii_txd <= ERR_COL;
                  xgmii_txc <= '1;
               end
            end
            ST_TERM: begin
               xgmii_txd <= TERM_COL;
               xgmii_txc <= '1;
               gleft     <= GW'(IPG_COLS - 1);
               state     <= ST_GAP;
            end
            ST_GAP: begin
               xgmii_txd <= IDLE_COL;
               xgmii_txc <= '1;
               gleft     <= gleft - GW'(1);
               if (gleft == GW'(1)) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xte_chk.sv
module xte_chk
   import xte_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned IPG_BYTES = 12,
   localparam int unsigned DW       = 8 * LANES
) (
   input logic             clk,
   input logic             rst_n,
   input logic             s_valid,
   input logic             s_ready,
   input logic [7:0]       s_byte0,
   input logic [DW-1:0]    txd,
   input logic [LANES-1:0] txc
);
   localparam int unsigned MIN_GAP = IPG_BYTES - LANES + 1;

   logic        start_col, start_stray, fd_col, all_idle, bad_ctrl;
   logic [15:0] fd_lane;
   logic        counting;
   logic [15:0] gcnt;

   always_comb begin
      start_col   = txc[0] && (txd[7:0] == XC_START);
      start_stray = 1'b0;
      fd_col      = 1'b0;
      fd_lane     = '0;
      all_idle    = &txc;
      bad_ctrl    = 1'b0;
      for (int i = LANES - 1; i >= 0; i--) begin
         logic [7:0] b;
         b = txd[8*i +: 8];
         if (i > 0 && txc[i] && b == XC_START) start_stray = 1'b1;
         if (txc[i] && b == XC_TERM) begin
            fd_col  = 1'b1;
            fd_lane = 16'(i);
         end
         if (!(txc[i] && b == XC_IDLE)) all_idle = 1'b0;
         if (txc[i] && b != XC_IDLE && b != XC_START && b != XC_TERM && b != XC_ERR)
            bad_ctrl = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         counting <= 1'b0;
         gcnt     <= '0;
      end else if (start_col) begin
         counting <= 1'b0;
      end else if (fd_col) begin
         counting <= 1'b1;
         gcnt     <= 16'(LANES) - fd_lane;
      end else if (all_idle && counting && gcnt < 16'hFF00) begin
         gcnt <= gcnt + 16'(LANES);
      end
   end

   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&txc) && txd == {LANES{XC_IDLE}} && !s_ready); // R1

   AST_START_ONLY_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      !start_stray); // R2

   AST_START_THEN_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_col |-> !txc[1] && txd[15:8] == XB_PRE); // R2

   AST_BEAT_PASSES_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_ready |=> !txc[0] && txd[7:0] == $past(s_byte0)); // R3

   AST_GAP_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      start_col && counting |-> gcnt >= 16'(MIN_GAP)); // R6

   AST_READY_AFTER_SFD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_ready) |-> !txc[LANES-1] && txd[DW-1 -: 8] == XB_SFD); // R7

   AST_NO_READY_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (fd_col || all_idle) |-> !s_ready); // R7

   AST_CTRL_CODES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_ctrl); // R10
endmodule

bind xgmii_tx_encap xte_chk #(.LANES(LANES), .IPG_BYTES(IPG_BYTES)) u_xte_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .s_valid(s_valid),
   .s_ready(s_ready),
   .s_byte0(s_data[7:0]),
   .txd    (xgmii_txd),
   .txc    (xgmii_txc)
);

// File: tb/test_xgmii_tx_encap.sv
module test_xgmii_tx_encap;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] s_data = '0;
   logic [3:0]  s_keep = '0;
   logic        s_valid = 1'b0;
   logic        s_last = 1'b0;
   logic        s_ready;
   logic [31:0] txd;
   logic [3:0]  txc;

   always #4 clk = ~clk;

   xgmii_tx_encap i_xgmii_tx_encap (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_data   (s_data),
      .s_keep   (s_keep),
      .s_valid  (s_valid),
      .s_last   (s_last),
      .s_ready  (s_ready),
      .xgmii_txd(txd),
      .xgmii_txc(txc)
   );

   typedef struct {
      logic [31:0] d;
      logic [3:0]  c;
      bit          strict;
      string       tag;
   } col_t;

   col_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   dic_m  = 0;
   int   frame_no = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;

   localparam logic [31:0] IDLE_D  = 32'h07070707;
   localparam logic [31:0] START_D = 32'h555555FB;
   localparam logic [31:0] PRE_D   = 32'hD5555555;

   function automatic logic [7:0] fbyte(int f, int i);
      return 8'(f * 37 + i + 1);
   endfunction

   task automatic push(logic [31:0] d, logic [3:0] c, bit strict, string tag);
      col_t e;
      e.d = d; e.c = c; e.strict = strict; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: pushes the expected columns, then offers the beats
   task automatic send_frame(int len, bit strict, int err_at);
      int nb, c, f;
      f  = frame_no++;
      nb = (len + 3) / 4;
      c  = len - 4 * (nb - 1);
      push(START_D, 4'b0001, strict, "R2");
      push(PRE_D, 4'b0000, 1'b0, "R2");
      for (int b = 0; b < nb; b++) begin
         logic [31:0] d;
         logic [3:0]  cc;
         if (b == err_at) push(32'hFEFEFEFE, 4'hF, 1'b0, "R8");
         d = '0; cc = '0;
         for (int l = 0; l < 4; l++) begin
            if (b < nb - 1 || l < c) d[8*l +: 8] = fbyte(f, 4 * b + l);
            else begin
               cc[l] = 1'b1;
               d[8*l +: 8] = (l == c) ? 8'hFD : 8'h07;
            end
         end
         push(d, cc, 1'b0, (b == nb - 1) ? "R4" : "R3");
      end
      if (c == 4) begin
         push(32'h070707FD, 4'hF, 1'b0, "R4");
         for (int k = 0; k < 2; k++) push(IDLE_D, 4'hF, 1'b0, "R5 R6");
      end else if (dic_m + c <= 3) begin
         dic_m += c;   // gap 12 - c
         for (int k = 0; k < 2; k++) push(IDLE_D, 4'hF, 1'b0, "R5 R6");
      end else begin
         dic_m -= 4 - c;   // gap 16 - c
         for (int k = 0; k < 3; k++) push(IDLE_D, 4'hF, 1'b0, "R5 R6");
      end
      for (int b = 0; b < nb; b++) begin
         if (b == err_at && b > 0) begin
            s_valid = 1'b0;
            @(posedge clk); #1;
         end
         for (int l = 0; l < 4; l++) begin
            s_data[8*l +: 8] = fbyte(f, 4 * b + l);
            s_keep[l] = (b < nb - 1) || (l < c);
         end
         s_last  = (b == nb - 1);
         s_valid = 1'b1;
         forever begin
            @(negedge clk);
            if (s_ready) begin
               @(posedge clk); #1;
               break;
            end
         end
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
   endtask

   // monitor: compares every output column with the scoreboard
   always @(negedge clk) begin
      if (mon_en && !done) begin
         bit idle_now, legal;
         idle_now = (txd == IDLE_D) && (txc == 4'hF);
         legal = 1'b1;
         for (int l = 0; l < 4; l++)
            if (txc[l] && !(txd[8*l +: 8] inside {8'h07, 8'hFB, 8'hFD, 8'hFE})) legal = 1'b0;
         check(legal, "R10", {28'd0, txc, txd}, 64'd0);
         if (exp_q.size() == 0) begin
            check(idle_now, "R1", {28'd0, txc, txd}, {28'd0, 4'hF, IDLE_D});
         end else if (exp_q[0].d == START_D && exp_q[0].c == 4'b0001 && idle_now) begin
            if (exp_q[0].strict)
               check(1'b0, "R9", {28'd0, txc, txd}, {28'd0, 4'b0001, START_D});
         end else begin
            col_t e;
            e = exp_q.pop_front();
            check(txd == e.d && txc == e.c, e.tag, {28'd0, txc, txd}, {28'd0, e.c, e.d});
            if (e.d == START_D && e.c == 4'b0001)
               check(!s_ready, "R7", {63'd0, s_ready}, 64'd0);
            if (e.d == PRE_D && e.c == 4'b0000)
               check(s_ready, "R7", {63'd0, s_ready}, 64'd1);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(txd == IDLE_D && txc == 4'hF && !s_ready, "R1 reset",
            {27'd0, s_ready, txc, txd}, {28'd0, 4'hF, IDLE_D});
      rst_n = 1'b1;
      @(posedge clk); #1;
      mon_en = 1'b1;
      repeat (4) @(posedge clk); #1;

      // single frame ending on a full column
      send_frame(8, 1'b0, -1);
      drain();

      // back-to-back burst walking the deficit count through every residue
      send_frame(5, 1'b0, -1);
      send_frame(5, 1'b1, -1);
      send_frame(5, 1'b1, -1);
      send_frame(5, 1'b1, -1);
      send_frame(6, 1'b1, -1);
      send_frame(6, 1'b1, -1);
      send_frame(7, 1'b1, -1);
      send_frame(7, 1'b1, -1);
      send_frame(8, 1'b1, -1);
      send_frame(1, 1'b1, -1);
      send_frame(2, 1'b1, -1);
      send_frame(3, 1'b1, -1);
      send_frame(4, 1'b1, -1);
      send_frame(9, 1'b1, -1);
      send_frame(13, 1'b1, -1);
      send_frame(11, 1'b1, -1);
      drain();

      // client stalls inside a frame
      send_frame(12, 1'b0, 1);
      send_frame(10, 1'b1, 2);
      drain();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule